// File: doc/BRIEF.md
# I2C Bit-Rate Divider

This block derives the timing tick that an I2C master's bus-phase logic uses to place SCL edges. A 7-bit rate register holds two fields: a 4-bit linear factor M and a 3-bit exponent N. The system clock is first divided by 2^N in a power-of-two prescaler. The result is then divided by (M+1) in a linear stage. One tick comes out every (M+1)·2^N clock cycles. Each SCL period covers ten ticks, so the SCL rate is the clock rate divided by 10·(M+1)·2^N.

A small phase counter runs on the ticks. It counts ten slots per SCL period and gives a reference level that is low for the first five slots and high for the last five. A write to the rate register, a soft reset, or a disabled controller restarts every counter stage. The first tick after any such event therefore honours the ratio in force at that moment.

Top module: `i2c_bitrate_div`

## Requirements
- R1: After reset the rate register reads 0x44 (M=8, N=4), the tick is low, the phase is 0 and the SCL reference is low.
- R2: A write stores wr_data_i in the rate register, with M taken from bits 6:3 and N from bits 2:0. The new value reads back on rate_o after the capturing clock edge.
- R3: While enabled, consecutive ticks are exactly (M+1)·2^N clock cycles apart. Each tick is a single-cycle high pulse when that product exceeds 1.
- R4: A write restarts both divider stages. The first tick after it appears on the (M+1)·2^N-th rising edge after the edge that captures the write, using the new M and N.
- R5: A soft reset restores the register to 0x44 and restarts the counters. It takes priority over a write in the same cycle.
- R6: While enable is low no tick is produced and the phase stays at 0. After enable returns, the first tick appears on the (M+1)·2^N-th rising edge at which enable is sampled high.
- R7: The phase value advances by one on every tick, going 0 through 9 and wrapping to 0. The SCL reference is high exactly for phases 5 to 9, so one SCL period spans 10 ticks with 5 low and 5 high.
- R8: The extremes of the ranges hold. M=0, N=0 gives a tick on every cycle. M=15, N=7 gives ticks 2048 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset of register and counters |
| en_i | input | 1 | Controller enable; ticks suppressed while low |
| wr_en_i | input | 1 | Rate register write strobe |
| wr_data_i | input | 7 | Rate register write value {M, N} |
| rate_o | output | 7 | Current rate register value |
| tick_o | output | 1 | One tick per (M+1)·2^N cycles |
| phase_o | output | 4 | Slot within the SCL period, 0 to 9 |
| scl_ref_o | output | 1 | SCL reference level, high for phases 5 to 9 |

## Verification
The assertions take the control inputs to be synchronous and free of unknowns once reset is released. They also assume that a write strobe or soft reset is a single clock cycle, so that the restart check can see counters at zero on the following edge. The stimulus changes inputs only on falling edges and pulses each write and soft reset for exactly one cycle. It holds enable at a stable level through every period it measures, so every expected period follows from the programmed M and N alone.

// File: rtl/i2c_bitrate_pkg.sv
package i2c_bitrate_pkg;
    localparam int unsigned LIN_W_DEF   = 4;
    localparam int unsigned EXP_W_DEF   = 3;
    localparam int unsigned SLOTS_DEF   = 10;
    localparam logic [6:0]  RATE_RST    = 7'h44;

    // restart cause seen by the counter stages
    typedef enum logic [1:0] {
        RUN_FREE = 2'd0,
        RUN_HALT = 2'd1,
        RUN_LOAD = 2'd2
    } run_mode_e;
endpackage

// File: rtl/i2c_bitrate_reg.sv
module i2c_bitrate_reg #(
    parameter int unsigned         RW      = 7,
    parameter logic [RW-1:0]       RST_VAL = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          soft_rst_i,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_data_i,
    output logic [RW-1:0] rate_o
);
    typedef struct packed {
        logic [RW-1:0] rate;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst_i) begin
            st_d.rate = RST_VAL;
        end else if (wr_en_i) begin
            st_d.rate = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.rate <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_o = st_q.rate;

    p_soft_restore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (rate_o == RST_VAL));

    p_write_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !soft_rst_i) |=> (rate_o == $past(wr_data_i)));
endmodule

// File: rtl/i2c_bitrate_prescale.sv
module i2c_bitrate_prescale
    import i2c_bitrate_pkg::*;
#(
    parameter int unsigned EXP_W = 3,
    localparam int unsigned CW   = (1 << EXP_W) - 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  run_mode_e        mode_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             stage_o,
    output logic [CW-1:0]    cnt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t    st_d, st_q;
    logic [CW-1:0] limit;

    // limit = 2^N - 1
    always_comb begin
        limit = '0;
        for (int i = 0; i < CW; i++) begin
            if (i < int'(exp_i)) limit[i] = 1'b1;
        end
    end

    assign stage_o = (mode_i == RUN_FREE) && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (mode_i != RUN_FREE) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == limit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    p_pre_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == RUN_FREE) |-> (cnt_o <= limit));
endmodule

// File: rtl/i2c_bitrate_linear.sv
module i2c_bitrate_linear
    import i2c_bitrate_pkg::*;
#(
    parameter int unsigned LIN_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  run_mode_e        mode_i,
    input  logic             stage_i,
    input  logic [LIN_W-1:0] lin_i,
    output logic             adv_o,
    output logic             tick_o,
    output logic [LIN_W-1:0] cnt_o
);
    typedef struct packed {
        logic [LIN_W-1:0] cnt;
        logic             tick;
    } lin_state_t;

    lin_state_t st_d, st_q;

    assign adv_o = (mode_i == RUN_FREE) && stage_i && (st_q.cnt == lin_i);

    always_comb begin
        st_d      = st_q;
        st_d.tick = adv_o;
        if (mode_i != RUN_FREE) begin
            st_d.cnt = '0;
        end else if (stage_i) begin
            if (st_q.cnt == lin_i) st_d.cnt = '0;
            else                   st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
    assign cnt_o  = st_q.cnt;

    p_lin_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == RUN_FREE) |-> (cnt_o <= lin_i));
endmodule

// File: rtl/i2c_bitrate_phase.sv
module i2c_bitrate_phase
    import i2c_bitrate_pkg::*;
#(
    parameter int unsigned SLOTS = 10,
    localparam int unsigned PW   = $clog2(SLOTS),
    localparam int unsigned HALF = SLOTS / 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  run_mode_e     mode_i,
    input  logic          adv_i,
    output logic [PW-1:0] phase_o,
    output logic          scl_ref_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
        logic          lvl;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_i != RUN_FREE) begin
            st_d.phase = '0;
        end else if (adv_i) begin
            if (st_q.phase == PW'(SLOTS - 1)) st_d.phase = '0;
            else                               st_d.phase = st_q.phase + 1'b1;
        end
        st_d.lvl = (st_d.phase >= PW'(HALF));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign scl_ref_o = st_q.lvl;

    p_phase_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o < PW'(SLOTS));

    p_phase_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == RUN_FREE && !adv_i) |=> $stable(phase_o));
endmodule

// File: rtl/i2c_bitrate_div.sv
module i2c_bitrate_div
    import i2c_bitrate_pkg::*;
#(
    parameter int unsigned LIN_W = LIN_W_DEF,
    parameter int unsigned EXP_W = EXP_W_DEF,
    parameter int unsigned SLOTS = SLOTS_DEF,
    localparam int unsigned RW   = LIN_W + EXP_W,
    localparam int unsigned PW   = $clog2(SLOTS),
    localparam int unsigned CW   = (1 << EXP_W) - 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          soft_rst_i,
    input  logic          en_i,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_data_i,
    output logic [RW-1:0] rate_o,
    output logic          tick_o,
    output logic [PW-1:0] phase_o,
    output logic          scl_ref_o
);
    run_mode_e        mode;
    logic             stage;
    logic             adv;
    logic [CW-1:0]    pre_cnt;
    logic [LIN_W-1:0] lin_cnt;

    always_comb begin
        if (soft_rst_i || wr_en_i) mode = RUN_LOAD;
        else if (!en_i)            mode = RUN_HALT;
        else                       mode = RUN_FREE;
    end

    i2c_bitrate_reg #(
        .RW      (RW),
        .RST_VAL (RW'(RATE_RST))
    ) u_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rate_o     (rate_o)
    );

    i2c_bitrate_prescale #(
        .EXP_W (EXP_W)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode),
        .exp_i   (rate_o[EXP_W-1:0]),
        .stage_o (stage),
        .cnt_o   (pre_cnt)
    );

    i2c_bitrate_linear #(
        .LIN_W (LIN_W)
    ) u_lin (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode),
        .stage_i (stage),
        .lin_i   (rate_o[RW-1:EXP_W]),
        .adv_o   (adv),
        .tick_o  (tick_o),
        .cnt_o   (lin_cnt)
    );

    i2c_bitrate_phase #(
        .SLOTS (SLOTS)
    ) u_ph (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode),
        .adv_i     (adv),
        .phase_o   (phase_o),
        .scl_ref_o (scl_ref_o)
    );

    p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i || soft_rst_i) |=> (pre_cnt == '0 && lin_cnt == '0 && !tick_o));

    p_quiet_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!tick_o && phase_o == '0));

    p_tick_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && rate_o != '0 && !wr_en_i && !soft_rst_i) |=> !tick_o);
endmodule

// File: tb/i2c_bitrate_div_test.sv
module i2c_bitrate_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [6:0] rate;
    logic       tick;
    logic [3:0] phase;
    logic       scl_ref;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_bitrate_div uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .soft_rst_i (soft_rst),
        .en_i       (en),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rate_o     (rate),
        .tick_o     (tick),
        .phase_o    (phase),
        .scl_ref_o  (scl_ref)
    );

    function automatic int period_of(input logic [6:0] v);
        return (int'(v[6:3]) + 1) * (1 << v[2:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write at a falling edge; returns at the falling edge after the capture
    task automatic do_write(input logic [6:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // negedges counted until tick is seen, starting at count 'start'
    task automatic wait_tick(input int start, output int n);
        n = start;
        while (!tick && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period_meas(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 5000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rate", int'(rate), 'h44);
        check("R1 tick", int'(tick), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 scl", int'(scl_ref), 0);
    endtask

    task automatic t_fields();
        do_write(7'b0011_010);   // M=3 bits6:3, N=2 bits2:0
        check("R2 readback", int'(rate), 'h1A);
        check("R2 field M", int'(rate[6:3]), 3);
        check("R2 field N", int'(rate[2:0]), 2);
    endtask

    task automatic t_periods();
        logic [6:0] pats [4] = '{7'h44, 7'h0B, 7'h51, 7'h27};
        int n;
        foreach (pats[i]) begin
            do_write(pats[i]);
            wait_tick(1, n);
            period_meas(n);
            check("R3 period", n, period_of(pats[i]));
            period_meas(n);
            check("R3 period repeat", n, period_of(pats[i]));
        end
    endtask

    task automatic t_restart();
        int n;
        do_write(7'h7F);
        repeat (37) @(negedge clk);
        do_write(7'h13);          // M=2 N=3 -> 24
        wait_tick(1, n);
        check("R4 first tick after write", n, period_of(7'h13) + 1);
    endtask

    task automatic t_soft();
        int n;
        do_write(7'h05);
        @(negedge clk);
        soft_rst = 1'b1;
        wr_en = 1'b1;
        wr_data = 7'h09;
        @(negedge clk);
        soft_rst = 1'b0;
        wr_en = 1'b0;
        check("R5 restore wins", int'(rate), 'h44);
        wait_tick(1, n);
        check("R5 restart", n, period_of(7'h44) + 1);
    endtask

    task automatic t_enable();
        int n;
        int seen;
        do_write(7'h0A);          // M=1 N=2 -> 8
        @(negedge clk);
        en = 1'b0;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (tick || phase != 0) seen++;
        end
        check("R6 quiet while disabled", seen, 0);
        en = 1'b1;
        wait_tick(0, n);
        if (n == 0) begin
            @(negedge clk);
            n = 1;
            wait_tick(1, n);
        end
        check("R6 first tick after enable", n, period_of(7'h0A));
    endtask

    task automatic t_phase();
        int bad_ph = 0;
        int bad_l = 0;
        do_write(7'h00);          // tick every cycle
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            if (int'(phase) != (k % 10)) bad_ph++;
            if (int'(scl_ref) != ((k % 10) >= 5 ? 1 : 0)) bad_l++;
        end
        check("R7 phase sequence", bad_ph, 0);
        check("R7 scl reference", bad_l, 0);
    endtask

    task automatic t_extremes();
        int n;
        do_write(7'h00);
        period_meas(n);
        check("R8 fastest", n, 1);
        do_write(7'h7F);
        wait_tick(1, n);
        check("R8 slowest first", n, 2049);
        period_meas(n);
        check("R8 slowest period", n, 2048);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        en = 1'b1;
        t_fields();
        t_periods();
        t_restart();
        t_soft();
        t_enable();
        t_phase();
        t_extremes();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule